// File: doc/BRIEF.md
# Switch Processor Memory Access Port

This block is the host-side access port of a time slot switch. An 8-bit host bus, with six address lines, an active-low chip select, an active-low data strobe and a read/write line, reaches one control byte and three per-channel memories: data memory, connection memory low and connection memory high. The address space holds the control byte and a 32-channel window. The control byte selects which memory the window opens onto and which stream (a 32-channel block inside that memory) it covers. A split mode sends reads to data memory and writes to connection memory low, whatever memory is selected.

The memories are shared with the serial TDM side. The port posts a request and waits for the first cycle in which the TDM side leaves the memories free. It raises its acknowledge only when the access has finished, so the acknowledge delay varies with TDM traffic. Acknowledge then stays high until the host releases the strobe or the chip select. The processor-enable bit of the control byte is passed to the switching datapath.

Top module: `tsi_cpu_port`

## Requirements
- R1: While reset is applied and just after it is released, `ack` and `mem_req` are 0, `proc_en` is 0 and the control byte reads back as 0x00.
- R2: An access with `addr[5]`=0 and `addr[1:0]`=00 reaches the control byte, whatever `addr[4:2]` holds. The byte's fields are: bit 7 split mode, bit 6 processor enable, bits 4:3 memory select, bits 2:0 stream. Bit 5 always reads 0. `ack` rises one clock after the strobe is sampled.
- R3: The memory select encoding is 01 data memory, 10 connection memory low and 11 connection memory high. `mem_sel` uses the same codes. A window access (`addr[5]`=1) uses `mem_addr` = {stream, `addr[4:0]`}.
- R4: With split mode set, window reads go to data memory and window writes go to connection memory low, whatever the memory select field holds.
- R5: The following accesses are acknowledged one clock after the strobe, raise no `mem_req`, read as 0x00 and change no memory: a window write to data memory, a window access with memory select 00 outside split mode, and any access with `addr[5]`=0 and `addr[1:0]`≠00.
- R6: A window access holds `mem_req`, with address, select and direction stable, until a cycle with `tdm_busy`=0. The memory operation happens in that cycle. A write acknowledges on the next clock. A read captures `mem_rdata` one clock after the grant and acknowledges then. `ack` is never high together with `mem_req`.
- R7: `ack` stays high while both `cs_n` and `ds_n` stay low, and drops one clock after either goes high. No new access starts before then.
- R8: `proc_en` follows control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Host address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid while ack is high |
| ack | output | 1 | Access complete |
| tdm_busy | input | 1 | TDM side owns the memories this cycle |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_sel | output | 2 | Target memory (01 data, 10 conn. low, 11 conn. high) |
| mem_addr | output | 8 | {stream, channel} |
| mem_wdata | output | 8 | Write data to memory |
| mem_rdata | input | 8 | Read data, valid the cycle after a granted read |
| proc_en | output | 1 | Processor enable to the switching datapath |

## Verification
The bench builds the block with its default widths: 8 data bits, a 3-bit stream field and a 5-bit channel field. At these widths every memory select code, split mode, and the first and last channel of a window can be reached through the 6-bit host address. A behavioural memory behind the port honours `tdm_busy`. The bench holds that input high for 0 to 4 cycles per access, which sets the acknowledge latency, and checks the latency exactly in cycles. The bench reads the memory contents back to confirm where each write landed.

// File: rtl/tsi_cpu_pkg.sv
package tsi_cpu_pkg;
    typedef enum logic [1:0] {
        MS_NONE = 2'b00,
        MS_DM   = 2'b01,
        MS_CML  = 2'b10,
        MS_CMH  = 2'b11
    } msel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RDATA,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        TG_NONE,
        TG_CREG,
        TG_MEM
    } tgt_e;

    localparam int CR_SPLIT   = 7;
    localparam int CR_PE      = 6;
    localparam int CR_RSVD    = 5;
    localparam int CR_MSEL_LO = 3;
endpackage

// File: rtl/tsi_cpu_ctrl.sv
module tsi_cpu_ctrl #(
    parameter int DW   = 8,
    parameter int ST_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rd_val,
    output logic            split,
    output logic            pe,
    output logic [1:0]      msel,
    output logic [ST_W-1:0] stream
);
    import tsi_cpu_pkg::*;

    localparam logic [DW-1:0] RD_MASK = ~(DW'(1) << CR_RSVD);

    logic [DW-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) ctrl_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign rd_val = ctrl_q & RD_MASK;
    assign split  = ctrl_q[CR_SPLIT];
    assign pe     = ctrl_q[CR_PE];
    assign msel   = ctrl_q[CR_MSEL_LO +: 2];
    assign stream = ctrl_q[ST_W-1:0];
endmodule

// File: rtl/tsi_cpu_decode.sv
module tsi_cpu_decode (
    input  logic                  win,
    input  logic [1:0]            lo,
    input  logic                  rd,
    input  logic                  split,
    input  logic [1:0]            msel,
    output tsi_cpu_pkg::tgt_e     tgt,
    output logic [1:0]            sel,
    output logic                  we
);
    import tsi_cpu_pkg::*;

    always_comb begin
        tgt = TG_NONE;
        sel = MS_NONE;
        we  = 1'b0;
        if (!win) begin
            tgt = (lo == 2'b00) ? TG_CREG : TG_NONE;
        end else if (split) begin
            tgt = TG_MEM;
            sel = rd ? MS_DM : MS_CML;
            we  = !rd;
        end else begin
            case (msel)
                MS_DM: begin
                    if (rd) begin
                        tgt = TG_MEM;
                        sel = MS_DM;
                    end
                end
                MS_CML, MS_CMH: begin
                    tgt = TG_MEM;
                    sel = msel;
                    we  = !rd;
                end
                default: tgt = TG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port #(
    parameter int DW   = 8,
    parameter int ST_W = 3,
    parameter int CH_W = 5,
    localparam int AW  = CH_W + 1,
    localparam int MAW = ST_W + CH_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           ds_n,
    input  logic           rd_wr,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           ack,
    input  logic           tdm_busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [1:0]     mem_sel,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           proc_en
);
    import tsi_cpu_pkg::*;

    typedef struct packed {
        state_e         state;
        logic [1:0]     sel;
        logic           we;
        logic [MAW-1:0] maddr;
        logic [DW-1:0]  wd;
        logic [DW-1:0]  rd;
    } regs_t;

    regs_t r_d, r_q;

    logic            creg_we;
    logic [DW-1:0]   creg_val;
    logic            split;
    logic [1:0]      msel;
    logic [ST_W-1:0] stream;
    tgt_e            tgt;
    logic [1:0]      dec_sel;
    logic            dec_we;
    logic            strobe;

    assign strobe = !cs_n && !ds_n;

    tsi_cpu_ctrl #(.DW(DW), .ST_W(ST_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (creg_we),
        .wdata  (wdata),
        .rd_val (creg_val),
        .split  (split),
        .pe     (proc_en),
        .msel   (msel),
        .stream (stream)
    );

    tsi_cpu_decode u_dec (
        .win   (addr[AW-1]),
        .lo    (addr[1:0]),
        .rd    (rd_wr),
        .split (split),
        .msel  (msel),
        .tgt   (tgt),
        .sel   (dec_sel),
        .we    (dec_we)
    );

    always_comb begin
        r_d     = r_q;
        creg_we = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (strobe) begin
                    case (tgt)
                        TG_CREG: begin
                            creg_we = !rd_wr;
                            r_d.rd  = rd_wr ? creg_val : '0;
                            r_d.state = ST_DONE;
                        end
                        TG_MEM: begin
                            r_d.sel   = dec_sel;
                            r_d.we    = dec_we;
                            r_d.maddr = {stream, addr[CH_W-1:0]};
                            r_d.wd    = wdata;
                            r_d.rd    = '0;
                            r_d.state = ST_WAIT;
                        end
                        default: begin
                            r_d.rd    = '0;
                            r_d.state = ST_DONE;
                        end
                    endcase
                end
            end
            ST_WAIT: begin
                if (!tdm_busy) r_d.state = r_q.we ? ST_DONE : ST_RDATA;
            end
            ST_RDATA: begin
                r_d.rd    = mem_rdata;
                r_d.state = ST_DONE;
            end
            default: begin
                if (!strobe) r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, sel: MS_NONE, we: 1'b0,
                     maddr: '0, wd: '0, rd: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack       = (r_q.state == ST_DONE);
    assign mem_req   = (r_q.state == ST_WAIT);
    assign mem_we    = r_q.we;
    assign mem_sel   = r_q.sel;
    assign mem_addr  = r_q.maddr;
    assign mem_wdata = r_q.wd;
    assign rdata     = r_q.rd;
endmodule

// File: rtl/tsi_cpu_port_chk.sv
module tsi_cpu_port_chk #(
    parameter int MAW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic           ds_n,
    input logic           ack,
    input logic           tdm_busy,
    input logic           mem_req,
    input logic           mem_we,
    input logic [1:0]     mem_sel,
    input logic [MAW-1:0] mem_addr
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!ack && !mem_req));

    assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !cs_n && !ds_n) |=> ack);

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (cs_n || ds_n)) |=> !ack);

    assert_req_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && tdm_busy) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_sel) && $stable(mem_we)));

    assert_no_ack_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ack);

    assert_dm_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !(mem_we && mem_sel == 2'b01));
endmodule

bind tsi_cpu_port tsi_cpu_port_chk #(.MAW(MAW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .ds_n     (ds_n),
    .ack      (ack),
    .tdm_busy (tdm_busy),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_sel  (mem_sel),
    .mem_addr (mem_addr)
);

// File: tb/tsi_cpu_port_tb.sv
module tsi_cpu_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ds_n = 1'b1, rd_wr = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack;
    logic       tdm_busy = 1'b0;
    logic       mem_req, mem_we, proc_en;
    logic [1:0] mem_sel;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = '0;

    logic [7:0] bank [4][256];
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tsi_cpu_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rd_wr(rd_wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack),
        .tdm_busy(tdm_busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .proc_en(proc_en)
    );

    // behavioural shared memory: operates only when the TDM side is idle
    always @(posedge clk) begin
        if (mem_req && !tdm_busy) begin
            if (mem_we) bank[mem_sel][mem_addr] <= mem_wdata;
            else        mem_rdata <= bank[mem_sel][mem_addr];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {rd, addr[5:0], wdata, expected rdata, busy cycles, no-memory flag}
    localparam int NV = 19;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 6'h00, 8'h52, 8'h00, 3'd0, 1'b1},  // R2 pe=1 CML stream2
        {1'b1, 6'h00, 8'h00, 8'h52, 3'd0, 1'b1},  // R2
        {1'b0, 6'h25, 8'hA7, 8'h00, 3'd0, 1'b0},  // R3 CML write
        {1'b1, 6'h25, 8'h00, 8'hA7, 3'd3, 1'b0},  // R6 busy read
        {1'b0, 6'h00, 8'h19, 8'h00, 3'd0, 1'b1},  // CMH stream1
        {1'b0, 6'h3F, 8'h3C, 8'h00, 3'd4, 1'b0},  // R6 busy write
        {1'b1, 6'h3F, 8'h00, 8'h3C, 3'd2, 1'b0},  // R3 CMH read
        {1'b0, 6'h00, 8'h0F, 8'h00, 3'd0, 1'b1},  // DM stream7
        {1'b1, 6'h2A, 8'h00, 8'h4F, 3'd0, 1'b0},  // R3 DM read
        {1'b0, 6'h2A, 8'hFF, 8'h00, 3'd0, 1'b1},  // R5 DM write ignored
        {1'b1, 6'h2A, 8'h00, 8'h4F, 3'd1, 1'b0},  // R5 unchanged
        {1'b0, 6'h00, 8'h80, 8'h00, 3'd0, 1'b1},  // R4 split, msel 00
        {1'b0, 6'h21, 8'h66, 8'h00, 3'd0, 1'b0},  // R4 write -> CML
        {1'b1, 6'h21, 8'h00, 8'hA4, 3'd0, 1'b0},  // R4 read  -> DM
        {1'b1, 6'h04, 8'h00, 8'h80, 3'd0, 1'b1},  // R2 addr[4:2] ignored
        {1'b1, 6'h01, 8'h00, 8'h00, 3'd0, 1'b1},  // R5 unmapped
        {1'b0, 6'h00, 8'h27, 8'h00, 3'd0, 1'b1},  // R2 bit5 set
        {1'b1, 6'h00, 8'h00, 8'h07, 3'd0, 1'b1},  // R2 bit5 reads 0
        {1'b1, 6'h33, 8'h00, 8'h00, 3'd0, 1'b1}   // R5 msel 00 window
    };

    task automatic run_vec(input logic [26:0] v, input int idx);
        logic rd = v[26];
        int   b  = int'(v[3:1]);
        logic nm = v[0];
        int   lat, cnt;
        bit   saw_req;
        lat = nm ? 1 : ((b < 2 ? 2 : b + 1) + (rd ? 1 : 0));
        @(negedge clk);
        rd_wr = rd; addr = v[25:20]; wdata = v[19:12];
        cs_n = 1'b0; ds_n = 1'b0; tdm_busy = (b > 0);
        cnt = 0; saw_req = 0;
        while (!ack && cnt < 40) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (cnt >= b) tdm_busy = 1'b0;
            if (mem_req) saw_req = 1;
        end
        $display("vector %0d", idx);
        chk("R6 ack latency", cnt, lat);
        if (rd) chk("R2/R3/R4/R5 read data", rdata, v[11:4]);
        if (nm) chk("R5 no memory request", saw_req, 0);
        cs_n = 1'b1; ds_n = 1'b1;
        @(negedge clk);
        chk("R7 ack drop", ack, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bank[0][i] = 8'h00;
            bank[1][i] = 8'(i) ^ 8'hA5;
            bank[2][i] = 8'h00;
            bank[3][i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        chk("R1 ack in reset", ack, 0);
        chk("R1 mem_req in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 proc_en after reset", proc_en, 0);
        chk("R1 ack after reset", ack, 0);

        for (int k = 0; k < NV; k++) run_vec(VEC[k], k);

        chk("R3 CML stream2 ch5", bank[2][69], 8'hA7);
        chk("R3 CMH stream1 ch31", bank[3][63], 8'h3C);
        chk("R4 split write CML ch1", bank[2][1], 8'h66);
        chk("R5 DM untouched", bank[1][234], 8'h4F);
        chk("R4 CMH untouched", bank[3][1], 8'h00);

        // R8: processor enable follows bit 6
        run_vec({1'b0, 6'h00, 8'h40, 8'h00, 3'd0, 1'b1}, 100);
        chk("R8 proc_en set", proc_en, 1);
        run_vec({1'b0, 6'h00, 8'h00, 8'h00, 3'd0, 1'b1}, 101);
        chk("R8 proc_en clear", proc_en, 0);

        // R7: ack held while strobe held, no new access
        @(negedge clk);
        rd_wr = 1'b1; addr = 6'h00; cs_n = 1'b0; ds_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 ack held", ack, 1);
        chk("R7 no request while held", mem_req, 0);
        ds_n = 1'b1;
        @(negedge clk);
        chk("R7 ack drop on ds_n", ack, 0);
        cs_n = 1'b1;

        // R1: reset mid-access clears state and control byte
        run_vec({1'b0, 6'h00, 8'h5B, 8'h00, 3'd0, 1'b1}, 102);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_vec({1'b1, 6'h00, 8'h00, 8'h00, 3'd0, 1'b1}, 103);
        chk("R1 proc_en after re-reset", proc_en, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule